// File: doc/BRIEF.md
# Paged Address Translator and Chip-Select Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and a 20-bit physical memory map. It cuts the CPU address into a 4-bit virtual page number and a 12-bit offset. The virtual page picks one of 16 page-mapping registers, and that register supplies an 8-bit physical page. The offset passes through unchanged, so pages are 4 KB and 256 physical pages can be reached.

The physical page is then decoded into chip selects. The low half of the page space is RAM and the top eight pages are EEPROM. Every page in between is I/O. Within an I/O page, offset bits 11..8 pick one of 16 peripheral selects, and offset bits 7..0 go to that peripheral as its register select. Peripheral 0 is this block's own mapping table.

The block also forms active-low read and write strobes from the CPU read/write line and the E clock. While an external bus master owns the bus, the block decodes a supplied physical address in place of a translated one. This lets such a master rewrite the whole table on a context switch. Virtual page 0xF always reaches physical page 0xFF, so the vector fetch after reset comes from EEPROM.

Top module: `paged_mmu`

## Requirements
- R1: While the address is valid (cpu_e or cpu_q high) and ext_master is low, for virtual pages 0x0 to 0xE phys_addr equals {mapping register[cpu_addr[15:12]], cpu_addr[11:0]}.
- R2: Virtual page 0xF always translates to physical page 0xFF, whatever mapping register 15 holds. Register 15 can still be written and read back.
- R3: After a synchronous active-low reset, mapping registers 0 to 14 read 0x00 and register 15 reads 0xFF.
- R4: While the address is valid, exactly one select is high. cs_ram is high for pages 0x00–0x7F and cs_rom for pages 0xF8–0xFF. Any other page raises cs_io[phys_addr[11:8]].
- R5: While cpu_e and cpu_q are both low, phys_addr is 0, every chip select is low and cpu_rdata is 0.
- R6: rd_n is low exactly when cpu_e and cpu_rnw are both high. wr_n is low exactly when cpu_e is high and cpu_rnw is low.
- R7: At a clock edge where wr_n is low, cs_io[0] is high and phys_addr[7:4] is 0, mapping register phys_addr[3:0] takes cpu_wdata.
- R8: cpu_rdata returns mapping register phys_addr[3:0] while rd_n is low, cs_io[0] is high and phys_addr[7:4] is 0. Otherwise cpu_rdata is 0x00.
- R9: While ext_master is high and the address is valid, phys_addr equals ext_paddr and the selects decode from it.
- R10: A write to a peripheral-0 register offset from 0x10 to 0xFF changes no mapping register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU virtual address |
| cpu_wdata | input | 8 | Write data from the bus |
| cpu_rnw | input | 1 | High for a read, low for a write |
| cpu_e | input | 1 | CPU E clock |
| cpu_q | input | 1 | CPU Q clock |
| ext_master | input | 1 | High while an external master drives the bus |
| ext_paddr | input | 20 | Physical address from the external master |
| phys_addr | output | 20 | Physical page and offset |
| cs_ram | output | 1 | RAM select, active high |
| cs_rom | output | 1 | EEPROM select, active high |
| cs_io | output | 16 | Peripheral selects, one-hot |
| cpu_rdata | output | 8 | Mapping register read data |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Directed cases cover the following:
- the reset contents of the table;
- a first table write, made by the external master because reset leaves no virtual page pointing at I/O;
- the overridden page 0xF;
- writes to register offsets above 0x0F.

Random mapping values then separate a correct register index from a shifted or swapped one. Random CPU and external addresses cross every decode boundary (0x7F/0x80, 0xF7/0xF8) and all 16 peripheral numbers. Random E, Q and read/write levels separate the strobe gating from the address-valid gating.

// File: rtl/mmu_pkg.sv
// Shared sizes and types for the paged translator.
// Assumes a 16-bit virtual address, 4 KB pages and an 8-bit page number.
package mmu_pkg;
    localparam int VA_W    = 16;
    localparam int OFF_W   = 12;
    localparam int PPN_W   = 8;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PA_W    = PPN_W + OFF_W;
    localparam int NMAP    = 1 << VPN_W;
    localparam int PSEL_W  = 4;
    localparam int NPERIPH = 1 << PSEL_W;
    localparam int RSEL_W  = OFF_W - PSEL_W;
    typedef logic [PPN_W-1:0] ppn_t;
endpackage

// File: rtl/mmu_map_regs.sv
// Holds the mapping table: one physical page number per virtual page.
// Assumes one write port and two combinational read ports (translation, readback).
// The last entry resets to all ones; all other entries reset to zero.
module mmu_map_regs
    import mmu_pkg::*;
#(
    parameter int N_ENT = NMAP,
    parameter int IDX_W = VPN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ppn_t             wr_data,
    input  logic [IDX_W-1:0] xl_idx,
    output ppn_t             xl_ppn,
    input  logic [IDX_W-1:0] rb_idx,
    output ppn_t             rb_ppn
);
    ppn_t ent_q [N_ENT];

    // Table storage: reset image, then a single write per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++)
                ent_q[i] <= (i == N_ENT-1) ? '1 : '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_data;
        end
    end

    // Read ports.
    always_comb begin
        xl_ppn = ent_q[xl_idx];
        rb_ppn = ent_q[rb_idx];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_q[$past(wr_idx)] == $past(wr_data)); // R7
    AST_RESET_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ent_q[N_ENT-1] == '1 && ent_q[0] == '0)); // R3
endmodule

// File: rtl/mmu_xlate.sv
// Forms the physical address from either a translated CPU address or an
// external master's address. Assumes the caller looks up the table entry
// for vpn. The top virtual page is forced to the top physical page.
module mmu_xlate
    import mmu_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic             valid,
    input  logic             ext_master,
    input  logic [PA_W-1:0]  ext_pa,
    output logic [VPN_W-1:0] vpn,
    input  ppn_t             map_ppn,
    output logic [PA_W-1:0]  pa
);
    ppn_t ppn;

    // Page selection with the fixed vector page.
    always_comb begin
        vpn = va[VA_W-1:OFF_W];
        ppn = (vpn == '1) ? '1 : map_ppn;
        if (!valid)
            pa = '0;
        else if (ext_master)
            pa = ext_pa;
        else
            pa = {ppn, va[OFF_W-1:0]};
    end
endmodule

// File: rtl/mmu_decode.sv
// Decodes a physical address into RAM, EEPROM or one of the peripheral selects.
// Assumes the page boundaries given by the parameters. All selects are low when not valid.
module mmu_decode
    import mmu_pkg::*;
#(
    parameter logic [PPN_W-1:0] RAM_LAST  = 8'h7F,
    parameter logic [PPN_W-1:0] ROM_FIRST = 8'hF8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PA_W-1:0]     pa,
    input  logic                valid,
    output logic                cs_ram,
    output logic                cs_rom,
    output logic [NPERIPH-1:0]  cs_io,
    output logic [RSEL_W-1:0]   reg_sel
);
    ppn_t              page;
    logic              io_page;
    logic [PSEL_W-1:0] pnum;

    // Region classification of the physical page.
    always_comb begin
        page    = pa[PA_W-1:OFF_W];
        pnum    = pa[OFF_W-1:RSEL_W];
        reg_sel = pa[RSEL_W-1:0];
        cs_ram  = valid && (page <= RAM_LAST);
        cs_rom  = valid && (page >= ROM_FIRST);
        io_page = valid && (page > RAM_LAST) && (page < ROM_FIRST);
    end

    for (genvar g = 0; g < NPERIPH; g++) begin : g_io
        assign cs_io[g] = io_page && (pnum == PSEL_W'(g));
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_ram, cs_rom, cs_io})); // R4
    AST_SEL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $countones({cs_ram, cs_rom, cs_io}) == 1); // R4
endmodule

// File: rtl/paged_mmu.sv
// Top: page translation, chip-select decode, bus strobes, and the
// peripheral-0 port that reaches the mapping table.
// Assumes the address is valid while E or Q is high and strobes follow E.
module paged_mmu
    import mmu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                cpu_rnw,
    input  logic                cpu_e,
    input  logic                cpu_q,
    input  logic                ext_master,
    input  logic [19:0]         ext_paddr,
    output logic [19:0]         phys_addr,
    output logic                cs_ram,
    output logic                cs_rom,
    output logic [15:0]         cs_io,
    output logic [7:0]          cpu_rdata,
    output logic                rd_n,
    output logic                wr_n
);
    logic              addr_valid;
    logic [VPN_W-1:0]  vpn;
    ppn_t              xl_ppn;
    ppn_t              rb_ppn;
    logic [RSEL_W-1:0] reg_sel;
    logic              tbl_hit;
    logic              tbl_wr;

    // Bus qualification and strobes.
    always_comb begin
        addr_valid = cpu_e | cpu_q;
        rd_n       = ~(cpu_e & cpu_rnw);
        wr_n       = ~(cpu_e & ~cpu_rnw);
    end

    mmu_xlate i_xlate (
        .va         (cpu_addr),
        .valid      (addr_valid),
        .ext_master (ext_master),
        .ext_pa     (ext_paddr),
        .vpn        (vpn),
        .map_ppn    (xl_ppn),
        .pa         (phys_addr)
    );

    mmu_decode i_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .pa      (phys_addr),
        .valid   (addr_valid),
        .cs_ram  (cs_ram),
        .cs_rom  (cs_rom),
        .cs_io   (cs_io),
        .reg_sel (reg_sel)
    );

    // Table port decode: peripheral 0, register offsets 0x0..0xF only.
    always_comb begin
        tbl_hit   = cs_io[0] && (reg_sel[RSEL_W-1:VPN_W] == '0);
        tbl_wr    = tbl_hit && !wr_n;
        cpu_rdata = (tbl_hit && !rd_n) ? rb_ppn : '0;
    end

    mmu_map_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_idx  (reg_sel[VPN_W-1:0]),
        .wr_data (cpu_wdata),
        .xl_idx  (vpn),
        .xl_ppn  (xl_ppn),
        .rb_idx  (reg_sel[VPN_W-1:0]),
        .rb_ppn  (rb_ppn)
    );

    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_e |-> (rd_n && wr_n)); // R6
    AST_NO_SEL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_e || cpu_q) |-> (!cs_ram && !cs_rom && cs_io == '0 && phys_addr == '0)); // R5
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> cpu_rdata == '0); // R8
    AST_VECTOR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_e && !ext_master && cpu_addr[15:12] == 4'hF) |-> phys_addr[19:12] == 8'hFF); // R2
endmodule

// File: tb/test_paged_mmu.sv
module test_paged_mmu;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0;
    logic        cpu_rnw = 1, cpu_e = 0, cpu_q = 0, ext_master = 0;
    logic [19:0] ext_paddr = 0;
    logic [19:0] phys_addr;
    logic        cs_ram, cs_rom, rd_n, wr_n;
    logic [15:0] cs_io;
    logic [7:0]  cpu_rdata;

    int checks = 0, errors = 0;
    logic [7:0] mdl [16];

    always #5 clk = ~clk;

    paged_mmu i_paged_mmu (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] f_pa(logic [15:0] a, logic ext, logic [19:0] ep, logic v);
        if (!v) return 20'h0;
        if (ext) return ep;
        if (a[15:12] == 4'hF) return {8'hFF, a[11:0]};
        return {mdl[a[15:12]], a[11:0]};
    endfunction

    function automatic logic [17:0] f_cs(logic [19:0] pa, logic v);
        logic [17:0] r = '0;
        if (!v) return r;
        if (pa[19:12] <= 8'h7F) r[17] = 1;
        else if (pa[19:12] >= 8'hF8) r[16] = 1;
        else r[pa[11:8]] = 1;
        return r;
    endfunction

    // Drive one bus state, check all outputs, then let a clock edge pass.
    task automatic access(input logic [15:0] a, input logic rnw, input logic e, input logic q,
                          input logic ext, input logic [19:0] ep, input logic [7:0] wd);
        logic [19:0] pa;
        logic [17:0] cs;
        logic        v, hit;
        @(negedge clk);
        cpu_addr = a; cpu_rnw = rnw; cpu_e = e; cpu_q = q;
        ext_master = ext; ext_paddr = ep; cpu_wdata = wd;
        #1;
        v   = e | q;
        pa  = f_pa(a, ext, ep, v);
        cs  = f_cs(pa, v);
        hit = cs[0] && pa[7:4] == 4'h0;
        if (!v)                             chk("R5 phys_addr", phys_addr, pa);
        else if (ext)                       chk("R9 phys_addr", phys_addr, pa);
        else if (a[15:12] == 4'hF)          chk("R2 phys_addr", phys_addr, pa);
        else                                chk("R1 phys_addr", phys_addr, pa);
        chk(v ? "R4 selects" : "R5 selects", {cs_ram, cs_rom, cs_io}, cs);
        chk("R6 strobes", {rd_n, wr_n}, {~(e & rnw), ~(e & ~rnw)});
        chk("R8 rdata", cpu_rdata, (e && rnw && hit) ? mdl[pa[3:0]] : 8'h00);
        @(posedge clk);
        if (e && !rnw && hit) mdl[pa[3:0]] = wd;
    endtask

    task automatic tbl_rd(input logic [3:0] idx, input string req, input logic [7:0] exp);
        @(negedge clk);
        cpu_e = 1; cpu_q = 1; cpu_rnw = 1; ext_master = 1;
        ext_paddr = {8'h80, 4'h0, 4'h0, idx};
        #1;
        chk(req, cpu_rdata, exp);
        @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = (i == 15) ? 8'hFF : 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R3 reset image read back through peripheral 0.
        for (int i = 0; i < 16; i++) tbl_rd(4'(i), "R3 reset", (i == 15) ? 8'hFF : 8'h00);
        // R5 idle bus.
        access(16'h1234, 1, 0, 0, 0, 20'h0, 8'h00);
        // R7 first mapping written by the external master: page 1 -> 0x80.
        access(16'h0, 0, 1, 1, 1, 20'h80001, 8'h80);
        tbl_rd(4'h1, "R7 write", 8'h80);
        // R7 CPU writes through virtual page 1.
        access(16'h1003, 0, 1, 1, 0, 20'h0, 8'h5A);
        tbl_rd(4'h3, "R7 cpu write", 8'h5A);
        access(16'h3ABC, 1, 1, 0, 0, 20'h0, 8'h00);
        // R10 offsets above 0x0F are ignored.
        access(16'h1015, 0, 1, 1, 0, 20'h0, 8'hC3);
        tbl_rd(4'h5, "R10 ignored", 8'h00);
        access(16'h10F3, 0, 1, 1, 0, 20'h0, 8'hC3);
        tbl_rd(4'h3, "R10 ignored", 8'h5A);
        // R2 entry 15 rewritten, vector page still fixed.
        access(16'h100F, 0, 1, 1, 0, 20'h0, 8'h12);
        tbl_rd(4'hF, "R2 readback", 8'h12);
        access(16'hFFFE, 1, 1, 1, 0, 20'h0, 8'h00);
        // R4 boundaries via the external master.
        access(16'h0, 1, 1, 1, 1, 20'h7FFFF, 8'h0);
        access(16'h0, 1, 1, 1, 1, 20'h80F00, 8'h0);
        access(16'h0, 1, 1, 1, 1, 20'hF7A00, 8'h0);
        access(16'h0, 1, 1, 1, 1, 20'hF8000, 8'h0);
        // Random traffic; page 1 stays routed to the table.
        void'($urandom(32'd1234));
        for (int n = 0; n < 600; n++) begin
            logic ext;
            logic [19:0] ep;
            logic [15:0] a;
            ext = ($urandom % 3) == 0;
            ep  = 20'($urandom);
            if ($urandom % 2) ep = {8'($urandom_range(8'h80, 8'hF7)), 4'h0, 8'($urandom % 32)};
            if (ep[7:0] == 8'h01) ep[7:0] = 8'h02;
            a = 16'($urandom);
            if ($urandom % 3 == 0) a = {4'h1, 4'h0, 4'h0, 4'($urandom)};
            if (a[15:12] == 4'h1 && a[11:0] == 12'h001) a[0] = 0;
            access(a, 1'($urandom), 1'($urandom), 1'($urandom), ext, ep, 8'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule